// File: doc/BRIEF.md
# Stream-attached UART with end-of-packet marking

This block joins a full-duplex asynchronous serial line to two AXI4-Stream ports. The transmit half accepts bytes on a stream slave and shifts each one out as an 8N1 frame, least significant bit first. The receive half synchronises the incoming line, recovers 8N1 frames by sampling each bit in its middle, and offers every good byte on a stream master.

Each received byte that equals a configurable end-of-packet code carries TLAST. A downstream DMA engine can therefore close its buffer on that beat, so a plain serial byte stream arrives as separate packets. The bit period is a whole number of system clocks. At the default of 10 clocks per bit, a 120 MHz clock gives 12 Mbit/s. The two halves share nothing and run at the same time.

A stop bit that reads low drops the byte and raises a one-cycle framing-error pulse. A byte that completes while the output beat is still blocked is dropped: the older beat is kept and a one-cycle overrun pulse is raised.

Top module: `axis_uart_pkt`

## Requirements
- R1: While and after reset, before any traffic, tx_o is high, s_axis_tready_o is high, m_axis_tvalid_o is low, and frame_err_o and overrun_o are low.
- R2: A byte accepted on the slave port is sent as a frame of ten bits: one start bit at 0, data bits 0 to 7 in that order, and one stop bit at 1. Each bit lasts CLKS_PER_BIT clocks.
- R3: s_axis_tready_o is high only while the transmitter is idle. After a handshake it stays low for exactly 10*CLKS_PER_BIT clocks, and the start bit begins in the cycle after the handshake.
- R4: The line rx_i passes through a two-flop synchroniser. The receiver samples each bit CLKS_PER_BIT/2 clocks into the bit. A frame with a high stop bit yields one beat on the master port, carrying the data bits in LSB-first order.
- R5: m_axis_tlast_o is high on a beat exactly when m_axis_tdata_o equals EOP_CODE (default 8'h7F).
- R6: Once m_axis_tvalid_o is high, it stays high and m_axis_tdata_o and m_axis_tlast_o stay unchanged until a cycle with m_axis_tready_i high.
- R7: When the stop bit samples low, no beat is produced and frame_err_o pulses high for exactly one cycle.
- R8: A byte that completes while m_axis_tvalid_o is high and m_axis_tready_i is low is dropped. The held beat is kept unchanged, and overrun_o pulses high for one cycle in the following clock.
- R9: A low pulse on rx_i that is back high by the middle of the start bit is ignored. It produces no beat and no framing error.
- R10: Transmit and receive run at the same time without affecting each other's bytes or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_axis_tdata_i | input | DATA_W | Byte to transmit |
| s_axis_tvalid_i | input | 1 | Transmit byte valid |
| s_axis_tready_o | output | 1 | Transmitter idle, byte accepted |
| tx_o | output | 1 | Serial transmit line, idle high |
| rx_i | input | 1 | Serial receive line, asynchronous |
| m_axis_tdata_o | output | DATA_W | Received byte |
| m_axis_tvalid_o | output | 1 | Received beat valid |
| m_axis_tlast_o | output | 1 | Beat is the end-of-packet code |
| m_axis_tready_i | input | 1 | Downstream accepts beat |
| frame_err_o | output | 1 | One-cycle pulse on bad stop bit |
| overrun_o | output | 1 | One-cycle pulse on dropped byte |

## Verification
The assertions check the stream-level rules on every cycle. These are the hold of a blocked receive beat, the agreement of TLAST with the data, the single-cycle error pulses, the overrun keeping the held data, and the exact length of the transmit busy window. Only the bench's scenarios can show that bit values come out in the right order and at the right times on the line, and that sampled frames decode to the right bytes. The same holds for glitch rejection, for a framing error that drops its byte, and for full-duplex traffic that leaves both directions intact.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned FRAME_BITS = 10;  // start + 8 data + stop

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RECV = 1'b1
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       last;
  } rx_beat_t;
endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int unsigned CLKS_PER_BIT = 10,
  parameter int unsigned DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o
);
  localparam int unsigned NBITS = DATA_W + 2;
  localparam int unsigned CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int unsigned IDX_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NBITS - 1);

  logic             busy_q;
  logic [NBITS-1:0] frame_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             tx_q;

  assign ready_o = ~busy_q;
  assign tx_o    = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      cnt_q   <= '0;
      idx_q   <= '0;
      tx_q    <= 1'b1;
    end else if (!busy_q) begin
      if (valid_i) begin
        busy_q  <= 1'b1;
        frame_q <= {1'b1, data_i, 1'b0};
        cnt_q   <= '0;
        idx_q   <= '0;
        tx_q    <= 1'b0;
      end
    end else if (cnt_q == CNT_MAX) begin
      cnt_q <= '0;
      if (idx_q == IDX_MAX) begin
        busy_q <= 1'b0;
        tx_q   <= 1'b1;
      end else begin
        idx_q   <= idx_q + 1'b1;
        frame_q <= {1'b1, frame_q[NBITS-1:1]};
        tx_q    <= frame_q[1];
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 10,
  parameter int unsigned DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_s_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              ferr_o
);
  localparam int unsigned NBITS = DATA_W + 2;
  localparam int unsigned CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int unsigned IDX_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(CLKS_PER_BIT / 2);
  localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(NBITS - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              done_q, ferr_q;

  assign data_o = shift_q;
  assign done_o = done_q;
  assign ferr_o = ferr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ferr_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          if (!rx_s_i) begin
            state_q <= RX_RECV;
            cnt_q   <= '0;
            idx_q   <= '0;
          end
        end
        RX_RECV: begin
          cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
          if (cnt_q == CNT_MAX) idx_q <= idx_q + 1'b1;
          if (cnt_q == CNT_MID) begin
            if (idx_q == '0) begin
              if (rx_s_i) state_q <= RX_IDLE;  // glitch, not a start bit
            end else if (idx_q == IDX_STOP) begin
              state_q <= RX_IDLE;
              done_q  <= rx_s_i;
              ferr_q  <= ~rx_s_i;
            end else begin
              shift_q <= {rx_s_i, shift_q[DATA_W-1:1]};
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_axis_reg.sv
module uart_rx_axis_reg #(
  parameter int unsigned DATA_W   = 8,
  parameter logic [DATA_W-1:0] EOP_CODE = 8'h7F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] tdata_o,
  output logic              tvalid_o,
  output logic              tlast_o,
  input  logic              tready_i,
  output logic              overrun_o
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q, last_q, ovr_q;
  logic              slot_free;

  assign slot_free = ~valid_q | tready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      ovr_q <= 1'b0;
      if (valid_q && tready_i) valid_q <= 1'b0;
      if (done_i) begin
        if (slot_free) begin
          data_q  <= data_i;
          last_q  <= (data_i == EOP_CODE);
          valid_q <= 1'b1;
        end else begin
          ovr_q <= 1'b1;  // keep held beat
        end
      end
    end
  end

  assign tdata_o   = data_q;
  assign tvalid_o  = valid_q;
  assign tlast_o   = last_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/axis_uart_pkt.sv
module axis_uart_pkt
  import uart_pkg::*;
#(
  parameter int unsigned       CLKS_PER_BIT = 10,
  parameter int unsigned       DATA_W       = 8,
  parameter int unsigned       SYNC_STAGES  = 2,
  parameter logic [DATA_W-1:0] EOP_CODE     = 8'h7F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] s_axis_tdata_i,
  input  logic              s_axis_tvalid_i,
  output logic              s_axis_tready_o,
  output logic              tx_o,
  input  logic              rx_i,
  output logic [DATA_W-1:0] m_axis_tdata_o,
  output logic              m_axis_tvalid_o,
  output logic              m_axis_tlast_o,
  input  logic              m_axis_tready_i,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic              rx_s;
  logic [DATA_W-1:0] rx_data;
  logic              rx_done;

  uart_tx_core #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_W      (DATA_W)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (s_axis_tdata_i),
    .valid_i(s_axis_tvalid_i),
    .ready_o(s_axis_tready_o),
    .tx_o   (tx_o)
  );

  uart_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_core #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_W      (DATA_W)
  ) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_s_i(rx_s),
    .data_o(rx_data),
    .done_o(rx_done),
    .ferr_o(frame_err_o)
  );

  uart_rx_axis_reg #(
    .DATA_W  (DATA_W),
    .EOP_CODE(EOP_CODE)
  ) u_rx_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (rx_data),
    .done_i   (rx_done),
    .tdata_o  (m_axis_tdata_o),
    .tvalid_o (m_axis_tvalid_o),
    .tlast_o  (m_axis_tlast_o),
    .tready_i (m_axis_tready_i),
    .overrun_o(overrun_o)
  );
endmodule

// File: rtl/axis_uart_pkt_chk.sv
module axis_uart_pkt_chk #(
  parameter int unsigned       CLKS_PER_BIT = 10,
  parameter int unsigned       DATA_W       = 8,
  parameter logic [DATA_W-1:0] EOP_CODE     = 8'h7F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_axis_tvalid_i,
  input logic              s_axis_tready_o,
  input logic              tx_o,
  input logic [DATA_W-1:0] m_axis_tdata_o,
  input logic              m_axis_tvalid_o,
  input logic              m_axis_tlast_o,
  input logic              m_axis_tready_i,
  input logic              frame_err_o,
  input logic              overrun_o
);
  localparam int unsigned BUSY_LEN = (DATA_W + 2) * CLKS_PER_BIT;
  localparam int unsigned BC_W     = $clog2(BUSY_LEN + 2) + 1;

  logic [BC_W-1:0] busy_cnt_q;
  logic            sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt_q <= '0;
      sent_q     <= 1'b0;
    end else if (s_axis_tvalid_i && s_axis_tready_o) begin
      busy_cnt_q <= '0;
      sent_q     <= 1'b1;
    end else if (!s_axis_tready_o && busy_cnt_q != '1) begin
      busy_cnt_q <= busy_cnt_q + 1'b1;
    end
  end

  // R1: idle transmitter keeps the line high
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_axis_tready_o |-> tx_o);

  // R3: start bit follows the handshake
  p_start_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_axis_tvalid_i && s_axis_tready_o) |=> (!s_axis_tready_o && !tx_o));

  // R3: busy window is exactly one frame long
  p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(s_axis_tready_o) && sent_q) |-> (busy_cnt_q == BC_W'(BUSY_LEN)));

  // R5
  p_tlast_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_axis_tvalid_o |-> (m_axis_tlast_o == (m_axis_tdata_o == EOP_CODE)));

  // R6
  p_beat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_axis_tvalid_o && !m_axis_tready_i) |=>
      (m_axis_tvalid_o && $stable(m_axis_tdata_o) && $stable(m_axis_tlast_o)));

  // R7
  p_ferr_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);

  // R8: overrun only against a blocked beat, which survives
  p_ovr_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> (m_axis_tvalid_o && $past(m_axis_tvalid_o && !m_axis_tready_i)
                   && $stable(m_axis_tdata_o)));

  p_ovr_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> !overrun_o);
endmodule

bind axis_uart_pkt axis_uart_pkt_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT),
  .DATA_W      (DATA_W),
  .EOP_CODE    (EOP_CODE)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .s_axis_tvalid_i(s_axis_tvalid_i),
  .s_axis_tready_o(s_axis_tready_o),
  .tx_o           (tx_o),
  .m_axis_tdata_o (m_axis_tdata_o),
  .m_axis_tvalid_o(m_axis_tvalid_o),
  .m_axis_tlast_o (m_axis_tlast_o),
  .m_axis_tready_i(m_axis_tready_i),
  .frame_err_o    (frame_err_o),
  .overrun_o      (overrun_o)
);

// File: tb/axis_uart_pkt_tb_top.sv
`timescale 1ns/1ps
module axis_uart_pkt_tb_top;
  localparam int CPB = 10;
  localparam logic [7:0] EOP = 8'h7F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] s_tdata = '0;
  logic       s_tvalid = 1'b0;
  logic       s_tready;
  logic       tx;
  logic       rx = 1'b1;
  logic [7:0] m_tdata;
  logic       m_tvalid, m_tlast;
  logic       m_tready = 1'b1;
  logic       ferr, ovr;

  int checks = 0;
  int fails  = 0;
  int ferr_cnt = 0;
  int ovr_cnt  = 0;
  int cycles   = 0;
  bit done = 1'b0;

  logic [8:0] rx_exp_q[$];  // {last, data}
  logic [7:0] tx_exp_q[$];

  always #10 clk = ~clk;

  axis_uart_pkt dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .s_axis_tdata_i (s_tdata),
    .s_axis_tvalid_i(s_tvalid),
    .s_axis_tready_o(s_tready),
    .tx_o           (tx),
    .rx_i           (rx),
    .m_axis_tdata_o (m_tdata),
    .m_axis_tvalid_o(m_tvalid),
    .m_axis_tlast_o (m_tlast),
    .m_axis_tready_i(m_tready),
    .frame_err_o    (ferr),
    .overrun_o      (ovr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // pulse counters
  always @(negedge clk) begin
    if (rst_n && ferr) ferr_cnt++;
    if (rst_n && ovr)  ovr_cnt++;
  end

  // receive monitor: R4, R5
  always @(negedge clk) begin
    if (rst_n && m_tvalid && m_tready) begin
      if (rx_exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected beat", int'({m_tlast, m_tdata}), 0);
      end else begin
        logic [8:0] e;
        e = rx_exp_q.pop_front();
        check(m_tdata == e[7:0], "R4 rx data", m_tdata, e[7:0]);
        check(m_tlast == e[8], "R5 tlast", m_tlast, e[8]);
      end
    end
  end

  // transmit monitor: R2
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !tx) begin
        logic [7:0] got;
        logic       stop_b;
        repeat (CPB/2) @(negedge clk);
        check(tx == 1'b0, "R2 start bit", tx, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          got[i] = tx;
        end
        repeat (CPB) @(negedge clk);
        stop_b = tx;
        check(stop_b == 1'b1, "R2 stop bit", stop_b, 1);
        if (tx_exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected tx frame", got, 0);
        end else begin
          logic [7:0] e;
          e = tx_exp_q.pop_front();
          check(got == e, "R2 tx data", got, e);
        end
      end
    end
  end

  task automatic send_tx(input logic [7:0] b);
    int busy;
    tx_exp_q.push_back(b);
    @(posedge clk); #1;
    s_tdata  = b;
    s_tvalid = 1'b1;
    forever begin
      @(negedge clk);
      if (s_tready) break;
    end
    @(posedge clk); #1;
    s_tvalid = 1'b0;
    // R3: count busy cycles
    busy = 0;
    forever begin
      @(negedge clk);
      if (s_tready) break;
      busy++;
    end
    check(busy == 10*CPB, "R3 busy length", busy, 10*CPB);
  endtask

  task automatic drive_rx(input logic [7:0] b, input logic stop_b);
    logic [9:0] fr;
    fr = {stop_b, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      rx = fr[i];
      repeat (CPB-1) @(posedge clk);
    end
    @(posedge clk); #1;
    rx = 1'b1;
    repeat (CPB) @(posedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_exp_q.push_back({b == EOP, b});
    drive_rx(b, 1'b1);
  endtask

  task automatic settle();
    repeat (6*CPB) @(posedge clk);
    @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      check(1'b0, "watchdog", cycles, 150000);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(tx == 1'b1 && s_tready && !m_tvalid && !ferr && !ovr, "R1 reset state",
          {tx, s_tready, m_tvalid, ferr, ovr}, 5'b11000);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx == 1'b1 && s_tready && !m_tvalid && !ferr && !ovr, "R1 after reset",
          {tx, s_tready, m_tvalid, ferr, ovr}, 5'b11000);

    // R2/R3 transmit patterns
    send_tx(8'hA5);
    send_tx(8'h01);
    send_tx(8'h80);
    send_tx(8'hFF);
    send_tx(8'h00);
    settle();

    // R4/R5 receive, packet ended by EOP
    send_rx(8'h3C);
    send_rx(8'hC3);
    send_rx(EOP);
    send_rx(8'h7E);
    send_rx(8'h00);
    send_rx(EOP);
    settle();
    check(rx_exp_q.size() == 0, "R4 all beats delivered", rx_exp_q.size(), 0);

    // R7: bad stop bit
    drive_rx(8'h55, 1'b0);
    settle();
    check(ferr_cnt == 1, "R7 frame error pulses", ferr_cnt, 1);
    check(!m_tvalid, "R7 byte dropped", m_tvalid, 0);
    send_rx(8'h12);  // recovers afterwards
    settle();
    check(rx_exp_q.size() == 0, "R7 recovery beat", rx_exp_q.size(), 0);

    // R9: short glitch
    @(posedge clk); #1 rx = 1'b0;
    repeat (3) @(posedge clk);
    #1 rx = 1'b1;
    settle();
    check(!m_tvalid && ferr_cnt == 1, "R9 glitch ignored", {m_tvalid, ferr_cnt[3:0]}, 1);

    // R8/R6: overrun with blocked output
    @(posedge clk); #1 m_tready = 1'b0;
    send_rx(8'h11);
    drive_rx(8'h22, 1'b1);
    settle();
    check(ovr_cnt == 1, "R8 overrun pulses", ovr_cnt, 1);
    check(m_tvalid && m_tdata == 8'h11, "R6 R8 held beat kept", m_tdata, 8'h11);
    @(posedge clk); #1 m_tready = 1'b1;
    settle();
    check(rx_exp_q.size() == 0 && !m_tvalid, "R8 only old beat out", rx_exp_q.size(), 0);

    // R6: slow consumer, no overrun
    @(posedge clk); #1 m_tready = 1'b0;
    send_rx(EOP);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(m_tvalid && m_tdata == EOP && m_tlast, "R6 beat held", {m_tlast, m_tdata}, {1'b1, EOP});
    @(posedge clk); #1 m_tready = 1'b1;
    settle();

    // R10: both directions at once
    fork
      begin send_tx(8'h5A); send_tx(EOP); send_tx(8'hC0); end
      begin send_rx(8'h96); send_rx(8'h69); send_rx(EOP); end
    join
    settle();
    repeat (12*CPB) @(posedge clk);
    check(rx_exp_q.size() == 0, "R10 rx drained", rx_exp_q.size(), 0);
    check(tx_exp_q.size() == 0, "R10 tx drained", tx_exp_q.size(), 0);
    check(ovr_cnt == 1 && ferr_cnt == 1, "R10 no stray errors", ovr_cnt + ferr_cnt, 2);

    done = 1'b1;
    summary();
  end
endmodule